// File: doc/BRIEF.md
# Serial Flash Quad-Enable Sequencer

This block runs once after reset. It makes sure that an external serial NOR flash has its quad-enable status bit set before any quad-width reads begin. It acts as a single-bit SPI master in mode 0, with the clock idling low, data sampled on the rising edge and the most significant bit sent first. The serial clock comes from the system clock through an even divider.

The block first reads the flash status register and compares the result with a target value. When the value already matches, the block finishes at once. When it does not match, the block sets the write latch, writes the target value, and then keeps reading the status register until the write-in-progress bit clears. It ends with a one-cycle completion pulse and a sticky flag that shows whether a write took place.

The controller walks through these named states:
- `ST_GAP`: chip select is held high for the idle gap.
- `ST_LAUNCH`: one byte is started.
- `ST_SHIFT`: the controller waits for that byte to finish.
- `ST_EVAL`: chip select is released and the next transaction or the finish is chosen.
- `ST_DONE`: the completion pulse is driven.
- `ST_HALT`: the controller stays here for good.

The transitions are:
- `ST_GAP` moves to `ST_LAUNCH` when the gap count expires.
- `ST_LAUNCH` always moves to `ST_SHIFT`.
- `ST_SHIFT` moves to `ST_LAUNCH` after a byte that is not the last of its frame.
- `ST_SHIFT` moves to `ST_EVAL` after the last byte of its frame.
- `ST_EVAL` moves to `ST_GAP` when another transaction is needed.
- `ST_EVAL` moves to `ST_DONE` when the sequence is finished.
- `ST_DONE` always moves to `ST_HALT`.

The transaction kinds are a status read, a write-latch set and a status write.

Top module: `qe_enable_seq`

## Requirements
- R1: While reset is held, chip select is high, the serial clock is low, and both `done` and `programmed` are 0.
- R2: The serial clock period is CLK_DIV system clocks and its high phase is CLK_DIV/2 clocks. Bytes go out most significant bit first.
- R3: A status read is one chip-select frame of two bytes: opcode 0x05 and then the dummy byte 0x00. The status value is the byte received during the second byte, sampled on rising clock edges.
- R4: If the first status read returns exactly TARGET (default 0x40), no further frame is issued and `programmed` stays 0.
- R5: If the first status read differs from TARGET, the next frame is the single byte 0x06. The frame after that holds two bytes: 0x01 and then TARGET.
- R6: After the write, the status read frame is repeated while bit 0 of the returned status is 1. The first read with bit 0 equal to 0 ends the sequence, whatever its other bits are.
- R7: Chip select stays high for at least 2*CLK_DIV system clocks before every frame, including the first frame after reset.
- R8: `done` is high for exactly one cycle, once per reset. `programmed` rises only when the write path was taken and then holds.
- R9: The serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | One-cycle pulse when the sequence ends |
| programmed | output | 1 | Sticky flag: the status write was issued |

## Verification
Two things can fall in the same cycle. One is the capture of the last status bit. The other is the end of the frame that decides the next step: within one frame, the sampled write-in-progress bit must choose between stopping and issuing another poll. The bench makes the flash model hold write-in-progress for zero, one and three polls. Each time it compares the full list of decoded frames against the expected list, checks that exactly one `done` pulse appears, and checks that no frame follows it. Start values with unrelated bits set, including a value with bit 0 already set before any write, make sure the first-read comparison and the poll test are told apart.

// File: rtl/qe_seq_pkg.sv
package qe_seq_pkg;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_LAUNCH,
        ST_SHIFT,
        ST_EVAL,
        ST_DONE,
        ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        XF_STATUS_RD,
        XF_WR_LATCH,
        XF_STATUS_WR
    } xfer_e;

    localparam logic [7:0] OPC_STATUS_RD = 8'h05;
    localparam logic [7:0] OPC_WR_LATCH  = 8'h06;
    localparam logic [7:0] OPC_STATUS_WR = 8'h01;
    localparam logic [7:0] FILL_BYTE     = 8'h00;

endpackage

// File: rtl/qe_half_tick.sv
module qe_half_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    generate
        if (HALF == 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            logic [CW-1:0] cnt;
            assign tick = run && (cnt == CW'(HALF - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             cnt <= '0;
                else if (!run || tick)  cnt <= '0;
                else                    cnt <= cnt + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/qe_byte_shifter.sv
module qe_byte_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    logic       tick;
    logic [7:0] sh;
    logic [2:0] bits;

    qe_half_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    assign mosi = sh[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            sck       <= 1'b0;
            sh        <= '0;
            bits      <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (go && !busy) begin
                busy <= 1'b1;
                sh   <= tx_byte;
                bits <= '0;
                sck  <= 1'b0;
            end else if (busy && tick) begin
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bits == 3'd7) begin
                        busy      <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        sh   <= {sh[6:0], 1'b0};
                        bits <= bits + 1'b1;
                    end
                end
            end
        end
    end

    // clock only toggles inside a byte
    assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    // a byte is never restarted while one is in flight
    assert_go_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

endmodule

// File: rtl/qe_enable_seq.sv
module qe_enable_seq
    import qe_seq_pkg::*;
#(
    parameter int         CLK_DIV     = 4,
    parameter logic [7:0] TARGET      = 8'h40,
    parameter int         GAP_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic spi_cs_n,
    output logic spi_sck,
    output logic spi_mosi,
    input  logic spi_miso,
    output logic done,
    output logic programmed
);
    localparam int GAP_CYC = GAP_PERIODS * CLK_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam int HW      = $clog2(GAP_CYC + 2) + 1;

    seq_state_e state, nstate;
    xfer_e      xfer;
    logic       byte_idx;
    logic       wrote;
    logic [7:0] status;
    logic [GW-1:0] gap_cnt;

    logic       go, busy, byte_done, last_byte, finish;
    logic [7:0] tx_byte, rx_byte;

    qe_byte_shifter #(.DIV(CLK_DIV)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .busy     (busy),
        .rx_byte  (rx_byte),
        .byte_done(byte_done)
    );

    assign last_byte = (xfer == XF_WR_LATCH) || byte_idx;
    assign finish    = (xfer == XF_STATUS_RD) &&
                       (wrote ? !status[0] : (status == TARGET));

    always_comb begin
        unique case (xfer)
            XF_STATUS_RD: tx_byte = byte_idx ? FILL_BYTE : OPC_STATUS_RD;
            XF_WR_LATCH:  tx_byte = OPC_WR_LATCH;
            XF_STATUS_WR: tx_byte = byte_idx ? TARGET : OPC_STATUS_WR;
            default:      tx_byte = FILL_BYTE;
        endcase
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_GAP:    if (gap_cnt == GW'(GAP_CYC - 1)) nstate = ST_LAUNCH;
            ST_LAUNCH: nstate = ST_SHIFT;
            ST_SHIFT:  if (byte_done) nstate = last_byte ? ST_EVAL : ST_LAUNCH;
            ST_EVAL:   nstate = finish ? ST_DONE : ST_GAP;
            ST_DONE:   nstate = ST_HALT;
            ST_HALT:   nstate = ST_HALT;
            default:   nstate = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_GAP;
            xfer     <= XF_STATUS_RD;
            byte_idx <= 1'b0;
            wrote    <= 1'b0;
            status   <= '0;
            gap_cnt  <= '0;
        end else begin
            state   <= nstate;
            gap_cnt <= (state == ST_GAP) ? gap_cnt + 1'b1 : '0;
            if (state == ST_SHIFT && byte_done) begin
                if (!last_byte) byte_idx <= 1'b1;
                if (xfer == XF_STATUS_RD && byte_idx) status <= rx_byte;
            end
            if (state == ST_EVAL) begin
                byte_idx <= 1'b0;
                unique case (xfer)
                    XF_STATUS_RD: if (!finish && !wrote) xfer <= XF_WR_LATCH;
                    XF_WR_LATCH:  xfer <= XF_STATUS_WR;
                    XF_STATUS_WR: begin
                        xfer  <= XF_STATUS_RD;
                        wrote <= 1'b1;
                    end
                    default:      xfer <= XF_STATUS_RD;
                endcase
            end
        end
    end

    always_comb begin
        spi_cs_n   = !((state == ST_LAUNCH) || (state == ST_SHIFT));
        go         = (state == ST_LAUNCH);
        done       = (state == ST_DONE);
        programmed = wrote;
    end

    // checker: consecutive high cycles of chip select, saturating
    logic [HW-1:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               hi_cnt <= '0;
        else if (!spi_cs_n)                       hi_cnt <= '0;
        else if (hi_cnt != HW'(2 * CLK_DIV + 1))  hi_cnt <= hi_cnt + 1'b1;
    end

    assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> hi_cnt >= HW'(2 * CLK_DIV));
    assert_sck_low_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_prog_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        programmed |=> programmed);
    assert_done_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && !busy));

endmodule

// File: tb/qe_enable_seq_tb.sv
module qe_enable_seq_tb;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n, spi_sck, spi_mosi, spi_miso, done, programmed;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    qe_enable_seq #(.CLK_DIV(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_cs_n  (spi_cs_n),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .done      (done),
        .programmed(programmed)
    );

    // ---------------- behavioural flash ----------------
    logic [7:0]  sr;
    logic        wel;
    int          busy_left;
    int          busy_polls;
    int          bitpos;
    logic [7:0]  in_sh;
    logic [7:0]  cur[$];
    logic [23:0] log_q[$];
    logic [7:0]  sr_view;

    assign sr_view  = (busy_left > 0) ? (sr | 8'h01) : sr;
    assign spi_miso = (cur.size() == 1 && cur[0] == 8'h05) ? sr_view[3'(7 - bitpos)] : 1'b0;

    always @(negedge spi_cs_n) begin
        bitpos = 0;
        cur.delete();
    end

    always @(posedge spi_sck) begin
        in_sh  = {in_sh[6:0], spi_mosi};
        bitpos = bitpos + 1;
        if (bitpos == 8) begin
            cur.push_back(in_sh);
            bitpos = 0;
        end
    end

    always @(posedge spi_cs_n) begin
        if (rst_n && cur.size() > 0) begin
            log_q.push_back({8'(cur.size()), cur[0], (cur.size() > 1) ? cur[1] : 8'h00});
            if (cur[0] == 8'h06 && cur.size() == 1) wel = 1'b1;
            if (cur[0] == 8'h01 && cur.size() == 2 && wel) begin
                sr        = cur[1];
                busy_left = busy_polls;
                wel       = 1'b0;
            end
            if (cur[0] == 8'h05 && busy_left > 0) busy_left = busy_left - 1;
            cur.delete();
        end
    end

    // ---------------- per-clock monitors ----------------
    int done_cnt, sck_viol, hi_run, min_gap, sck_hi_w, hi_w_bad, rise_gap, rise_bad;
    logic prev_cs, prev_sck;

    always @(negedge clk) begin
        if (!rst_n) begin
            done_cnt = 0; sck_viol = 0; hi_run = 0; min_gap = 1 << 20;
            sck_hi_w = 0; hi_w_bad = 0; rise_gap = 0; rise_bad = 0;
            prev_cs = 1'b1; prev_sck = 1'b0;
        end else begin
            if (done) done_cnt++;
            if (spi_cs_n && spi_sck) sck_viol++;
            if (spi_cs_n) hi_run++;
            if (!spi_cs_n && prev_cs) begin
                if (hi_run < min_gap) min_gap = hi_run;
                hi_run = 0; rise_gap = 0;
            end
            if (spi_sck) sck_hi_w++;
            if (!spi_sck && prev_sck) begin
                if (sck_hi_w != DIV / 2) hi_w_bad++;
                sck_hi_w = 0;
            end
            rise_gap++;
            if (spi_sck && !prev_sck) begin
                // within a byte, rises are one serial period apart
                if (rise_gap != 0 && rise_gap < DIV && !spi_cs_n && bitpos != 0) rise_bad++;
                rise_gap = 0;
            end
            prev_cs = spi_cs_n; prev_sck = spi_sck;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic scenario(input logic [7:0] init_sr, input int polls);
        logic [23:0] exp_q[$];
        int n;
        rst_n = 1'b0;
        sr = init_sr; wel = 1'b0; busy_left = 0; busy_polls = polls;
        log_q.delete(); cur.delete(); bitpos = 0;
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        check(spi_sck == 1'b0 && done == 1'b0 && programmed == 1'b0, "R1 outputs",
              {spi_sck, done, programmed}, 0);
        rst_n = 1'b1;
        n = 0;
        while (done_cnt == 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (300) @(negedge clk);

        exp_q.push_back({8'd2, 8'h05, 8'h00});
        if (init_sr != 8'h40) begin
            exp_q.push_back({8'd1, 8'h06, 8'h00});
            exp_q.push_back({8'd2, 8'h01, 8'h40});
            for (int i = 0; i <= polls; i++) exp_q.push_back({8'd2, 8'h05, 8'h00});
        end
        check(log_q.size() == exp_q.size(), (init_sr == 8'h40) ? "R4 frame count" : "R6 frame count",
              log_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
            check(log_q[i] == exp_q[i], (i == 0) ? "R3 status read frame" : "R5 write frames / R6 poll",
                  log_q[i], exp_q[i]);
        check(done_cnt == 1, "R8 done pulses", done_cnt, 1);
        check(programmed == (init_sr != 8'h40), "R8 programmed / R4", programmed, init_sr != 8'h40);
        check(min_gap >= 2 * DIV, "R7 cs gap", min_gap, 2 * DIV);
        check(sck_viol == 0, "R9 sck while deselected", sck_viol, 0);
        check(hi_w_bad == 0 && rise_bad == 0, "R2 sck timing", hi_w_bad + rise_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        scenario(8'h40, 0);  // R4 already enabled
        scenario(8'h00, 0);  // R5 write, busy clears on first poll
        scenario(8'h00, 3);  // R6 three busy polls
        scenario(8'h42, 1);  // R5 unrelated bits set
        scenario(8'h41, 2);  // R6 bit0 set before write must not end early
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule